// File: doc/BRIEF.md
# Processor Status Register Unit

This unit keeps the live status word of a 32-bit core together with a saved copy of that word for each privileged mode. It carries out the move-to-status and move-from-status operations. It rewrites the status word when the core takes an exception. It puts the saved copy back when the core returns from a handler. It also tells the rest of the core which mode is active and whether that mode is privileged.

There are seven modes. Two of them count as unprivileged: user and a restricted "safe" mode. Five modes each own one saved bank: fast interrupt, interrupt, supervisor, abort and undefined. All state changes happen on the rising clock edge. The read path and the mode outputs are combinational views of the stored registers.

Top module: `psr_unit`

## Requirements
- R1: After reset, `cpsr` is 0x000000D3: supervisor mode, with bit 7 (interrupt disable) and bit 6 (fast-interrupt disable) set. Every saved bank holds zero. `privileged` is 1.
- R2: `curMode` shows `cpsr[4:0]` when it holds a known code. The known codes are user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011 and safe 00000. Any other code shows as 10000. `privileged` is 0 exactly when `curMode` is user or safe.
- R3: With `rdSaved`=0, `rdData` is `cpsr`. With `rdSaved`=1 in a privileged mode, `rdData` is the saved bank of the current mode. With `rdSaved`=1 in an unprivileged mode, `rdData` is `cpsr`.
- R4: A status write (`wrValid`) targets the saved bank of the current mode when `wrSaved`=1, and `cpsr` otherwise. Its source is `wrRegVal` when `wrUseImm`=0. When `wrUseImm`=1, the source is the zero-extended `wrImm8` rotated right by twice `wrRot`.
- R5: A status write with both `wrMaskFlags` and `wrMaskCtrl` low changes no state.
- R6: In an unprivileged mode, a status write changes no state if `wrSaved`=1, or if `wrMaskCtrl`=1 while `wrMaskFlags`=0.
- R7: When `wrMaskFlags`=1, bits 31:28 of the target take the source value, in any mode. Bits 27:8 of the target keep their value on every status write.
- R8: Bits 7:0 of the target take the source value only when `wrMaskCtrl`=1 and the mode is privileged. In an unprivileged mode, `cpsr[7:0]` changes only on exception entry.
- R9: On `excValid`, the saved bank of `excMode` receives the old `cpsr`. In `cpsr`, bit 7 is set, bit 6 takes `excFiqDis`, bits 4:0 take `excMode`, and all other bits are kept.
- R10: On `restoreReq` in a privileged mode, `cpsr` is loaded from the current mode's saved bank. In an unprivileged mode, `restoreReq` has no effect.
- R11: `flagsWe` loads `flagsIn` into `cpsr[31:28]` when no other operation writes `cpsr` in that cycle.
- R12: When several operations write `cpsr` in one cycle, the order is exception entry, then restore, then status write, then flag port. A saved-bank status write and a flag-port write in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wrValid | input | 1 | Status write operation this cycle |
| wrSaved | input | 1 | Status write targets the saved bank |
| wrUseImm | input | 1 | Source is the rotated immediate |
| wrMaskFlags | input | 1 | Field mask: condition-flag nibble |
| wrMaskCtrl | input | 1 | Field mask: control byte |
| wrImm8 | input | 8 | Immediate value |
| wrRot | input | 4 | Rotate amount (times two) |
| wrRegVal | input | 32 | General register source |
| rdSaved | input | 1 | Read selects the saved bank |
| rdData | output | 32 | Status read result |
| excValid | input | 1 | Exception entry this cycle |
| excMode | input | 5 | Mode code of the exception target |
| excFiqDis | input | 1 | New fast-interrupt-disable value |
| restoreReq | input | 1 | Copy saved bank into current status |
| flagsWe | input | 1 | Flag write from the ALU |
| flagsIn | input | 4 | New condition flags |
| cpsr | output | 32 | Current status word |
| curMode | output | 5 | Decoded current mode |
| privileged | output | 1 | Current mode is privileged |

## Verification
The riskiest overlap is exception entry landing in the same cycle as an ALU flag write. The bench raises both at once from user mode. It then checks two things: the new status carries the old flags, and the fast-interrupt bank holds the pre-exception word. The same scheme is applied to restore against a status write, and to a saved-bank write against a flag write. In each case the result is compared with the priority order in R12.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int XLEN      = 32;
  localparam int MODE_W    = 5;
  localparam int NUM_BANKS = 5;
  localparam int BANK_W    = 3;
  localparam logic [BANK_W-1:0] BANK_NONE = 3'd7;

  localparam logic [MODE_W-1:0] MODE_USR  = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ  = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ  = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC  = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT  = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND  = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SAFE = 5'b00000;

  typedef struct packed {
    logic excEntry;
    logic restore;
    logic msrCur;
    logic msrSaved;
    logic msrFlags;
    logic msrCtrl;
    logic aluFlags;
  } psr_strobe_t;

  function automatic logic [MODE_W-1:0] decodeMode(input logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ, MODE_IRQ, MODE_SVC, MODE_ABT, MODE_UND, MODE_SAFE: decodeMode = m;
      default: decodeMode = MODE_USR;
    endcase
  endfunction

  function automatic logic [BANK_W-1:0] bankOf(input logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ: bankOf = 3'd0;
      MODE_IRQ: bankOf = 3'd1;
      MODE_SVC: bankOf = 3'd2;
      MODE_ABT: bankOf = 3'd3;
      MODE_UND: bankOf = 3'd4;
      default:  bankOf = BANK_NONE;
    endcase
  endfunction
endpackage

// File: rtl/psr_ctrl.sv
module psr_ctrl
  import psr_pkg::*;
(
  input  logic        wrValid,
  input  logic        wrSaved,
  input  logic        wrMaskFlags,
  input  logic        wrMaskCtrl,
  input  logic        excValid,
  input  logic        restoreReq,
  input  logic        flagsWe,
  input  logic        privileged,
  output psr_strobe_t strb
);
  logic msrNop;
  logic msrGo;

  always_comb begin
    msrNop = (!wrMaskFlags && !wrMaskCtrl) ||
             (!privileged && (wrSaved || (!wrMaskFlags && wrMaskCtrl)));
    msrGo  = wrValid && !msrNop;

    strb.excEntry = excValid;
    strb.restore  = !excValid && restoreReq && privileged;
    strb.msrCur   = !excValid && !strb.restore && msrGo && !wrSaved;
    strb.msrSaved = !excValid && msrGo && wrSaved;
    strb.msrFlags = wrMaskFlags;
    strb.msrCtrl  = wrMaskCtrl && privileged;
    strb.aluFlags = flagsWe && !excValid && !strb.restore && !strb.msrCur;
  end
endmodule

// File: rtl/psr_dp.sv
module psr_dp
  import psr_pkg::*;
#(
  parameter int          IMM_W    = 8,
  parameter int          ROT_W    = 4,
  parameter logic [7:0]  RST_CTRL = 8'hD3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  psr_strobe_t       strb,
  input  logic              wrUseImm,
  input  logic [IMM_W-1:0]  wrImm8,
  input  logic [ROT_W-1:0]  wrRot,
  input  logic [XLEN-1:0]   wrRegVal,
  input  logic              rdSaved,
  input  logic [MODE_W-1:0] excMode,
  input  logic              excFiqDis,
  input  logic [3:0]        flagsIn,
  output logic [XLEN-1:0]   cpsrQ,
  output logic [XLEN-1:0]   rdData,
  output logic [MODE_W-1:0] curMode,
  output logic              privileged
);
  localparam int SH_W = ROT_W + 2;

  logic [XLEN-1:0]   savedQ [NUM_BANKS];
  logic [XLEN-1:0]   curSaved;
  logic [XLEN-1:0]   immExt;
  logic [XLEN-1:0]   srcVal;
  logic [XLEN-1:0]   baseVal;
  logic [XLEN-1:0]   merged;
  logic [XLEN-1:0]   cpsrNext;
  logic [SH_W-1:0]   shAmt;
  logic [BANK_W-1:0] curBank;
  logic [BANK_W-1:0] excBank;

  assign curMode    = decodeMode(cpsrQ[MODE_W-1:0]);
  assign privileged = (curMode != MODE_USR) && (curMode != MODE_SAFE);
  assign curBank    = bankOf(curMode);
  assign excBank    = bankOf(excMode);

  always_comb begin
    curSaved = cpsrQ;
    for (int b = 0; b < NUM_BANKS; b++)
      if (curBank == BANK_W'(b)) curSaved = savedQ[b];
  end

  assign rdData = rdSaved ? curSaved : cpsrQ;

  always_comb begin
    immExt  = XLEN'(wrImm8);
    shAmt   = {1'b0, wrRot, 1'b0};
    srcVal  = wrUseImm ? ((immExt >> shAmt) | (immExt << (SH_W'(XLEN) - shAmt)))
                       : wrRegVal;
    baseVal = strb.msrSaved ? curSaved : cpsrQ;
    merged  = {strb.msrFlags ? srcVal[31:28] : baseVal[31:28],
               baseVal[27:8],
               strb.msrCtrl ? srcVal[7:0] : baseVal[7:0]};
  end

  always_comb begin
    cpsrNext = cpsrQ;
    if (strb.excEntry)
      cpsrNext = {cpsrQ[31:8], 1'b1, excFiqDis, cpsrQ[5], excMode};
    else if (strb.restore)
      cpsrNext = curSaved;
    else if (strb.msrCur)
      cpsrNext = merged;
    else if (strb.aluFlags)
      cpsrNext = {flagsIn, cpsrQ[27:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpsrQ <= {{(XLEN-8){1'b0}}, RST_CTRL};
    else        cpsrQ <= cpsrNext;
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        savedQ[g] <= '0;
      else if (strb.excEntry && excBank == BANK_W'(g))
        savedQ[g] <= cpsrQ;
      else if (strb.msrSaved && curBank == BANK_W'(g))
        savedQ[g] <= merged;
    end
  end
endmodule

// File: rtl/psr_unit.sv
module psr_unit
  import psr_pkg::*;
#(
  parameter int         IMM_W    = 8,
  parameter int         ROT_W    = 4,
  parameter logic [7:0] RST_CTRL = 8'hD3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrValid,
  input  logic              wrSaved,
  input  logic              wrUseImm,
  input  logic              wrMaskFlags,
  input  logic              wrMaskCtrl,
  input  logic [IMM_W-1:0]  wrImm8,
  input  logic [ROT_W-1:0]  wrRot,
  input  logic [31:0]       wrRegVal,
  input  logic              rdSaved,
  output logic [31:0]       rdData,
  input  logic              excValid,
  input  logic [4:0]        excMode,
  input  logic              excFiqDis,
  input  logic              restoreReq,
  input  logic              flagsWe,
  input  logic [3:0]        flagsIn,
  output logic [31:0]       cpsr,
  output logic [4:0]        curMode,
  output logic              privileged
);
  psr_strobe_t strb;

  psr_ctrl u_ctrl (
    .wrValid(wrValid), .wrSaved(wrSaved), .wrMaskFlags(wrMaskFlags),
    .wrMaskCtrl(wrMaskCtrl), .excValid(excValid), .restoreReq(restoreReq),
    .flagsWe(flagsWe), .privileged(privileged), .strb(strb)
  );

  psr_dp #(.IMM_W(IMM_W), .ROT_W(ROT_W), .RST_CTRL(RST_CTRL)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrUseImm(wrUseImm),
    .wrImm8(wrImm8), .wrRot(wrRot), .wrRegVal(wrRegVal), .rdSaved(rdSaved),
    .excMode(excMode), .excFiqDis(excFiqDis), .flagsIn(flagsIn),
    .cpsrQ(cpsr), .rdData(rdData), .curMode(curMode), .privileged(privileged)
  );
endmodule

// File: rtl/psr_unit_chk.sv
module psr_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wrValid,
  input logic        wrSaved,
  input logic        wrMaskFlags,
  input logic        wrMaskCtrl,
  input logic        rdSaved,
  input logic [31:0] rdData,
  input logic        excValid,
  input logic [4:0]  excMode,
  input logic        restoreReq,
  input logic        flagsWe,
  input logic [31:0] cpsr,
  input logic        privileged
);
  a_r9_exc_mode: assert property (@(posedge clk) disable iff (!rst_n)
    excValid |=> (cpsr[7] && cpsr[4:0] == $past(excMode)));

  a_r9_saved_copy: assert property (@(posedge clk) disable iff (!rst_n)
    excValid |=> (!rdSaved || !privileged || rdData == $past(cpsr)));

  a_r8_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (!privileged && !excValid) |=> cpsr[7:0] == $past(cpsr[7:0]));

  a_r5_mask_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (wrValid && !wrMaskFlags && !wrMaskCtrl && !excValid && !restoreReq && !flagsWe)
    |=> $stable(cpsr));

  a_r6_unpriv_saved: assert property (@(posedge clk) disable iff (!rst_n)
    (!privileged && wrValid && wrSaved && !excValid && !flagsWe) |=> $stable(cpsr));

  a_r7_mid_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (!excValid && !restoreReq) |=> cpsr[27:8] == $past(cpsr[27:8]));
endmodule

bind psr_unit psr_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrSaved(wrSaved),
  .wrMaskFlags(wrMaskFlags), .wrMaskCtrl(wrMaskCtrl), .rdSaved(rdSaved),
  .rdData(rdData), .excValid(excValid), .excMode(excMode),
  .restoreReq(restoreReq), .flagsWe(flagsWe), .cpsr(cpsr),
  .privileged(privileged)
);

// File: tb/psr_unit_bench.sv
`timescale 1ns/1ps
module psr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrValid = 0, wrSaved = 0, wrUseImm = 0, wrMaskFlags = 0, wrMaskCtrl = 0;
  logic [7:0]  wrImm8 = '0;
  logic [3:0]  wrRot = '0;
  logic [31:0] wrRegVal = '0;
  logic        rdSaved = 0;
  logic [31:0] rdData;
  logic        excValid = 0, excFiqDis = 0, restoreReq = 0, flagsWe = 0;
  logic [4:0]  excMode = '0;
  logic [3:0]  flagsIn = '0;
  logic [31:0] cpsr;
  logic [4:0]  curMode;
  logic        privileged;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  always #2.5 clk = ~clk;

  psr_unit u_psr_unit (.*);

  // {startCtl, {sv,imm,mF,mC}, imm8, rot, regVal, expCpsr, expRead}
  localparam int NV = 11;
  localparam logic [119:0] VEC [NV] = '{
    {8'hD3, 4'b0011, 8'h00, 4'h0, 32'hF000_0011, 32'hF000_0011, 32'h0000_0000},
    {8'hD3, 4'b0010, 8'h00, 4'h0, 32'hA000_0000, 32'hA000_00D3, 32'h0000_0000},
    {8'hD3, 4'b0101, 8'hD2, 4'h0, 32'h0000_0000, 32'h0000_00D2, 32'h0000_0000},
    {8'hD3, 4'b0110, 8'h09, 4'h2, 32'h0000_0000, 32'h9000_00D3, 32'h0000_0000},
    {8'hD3, 4'b1011, 8'h00, 4'h0, 32'h6000_001B, 32'h0000_00D3, 32'h6000_001B},
    {8'hD3, 4'b0000, 8'h00, 4'h0, 32'hFFFF_FFFF, 32'h0000_00D3, 32'h0000_0000},
    {8'h10, 4'b0011, 8'h00, 4'h0, 32'hF000_00D3, 32'hF000_0010, 32'hF000_0010},
    {8'h10, 4'b0001, 8'h00, 4'h0, 32'h0000_00D3, 32'h0000_0010, 32'h0000_0010},
    {8'h10, 4'b1010, 8'h00, 4'h0, 32'hF000_0000, 32'h0000_0010, 32'h0000_0010},
    {8'h00, 4'b0010, 8'h00, 4'h0, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000},
    {8'h17, 4'b1111, 8'h1B, 4'h0, 32'h0000_0000, 32'h0000_0017, 32'h0000_001B}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    wrValid = 0; wrSaved = 0; wrUseImm = 0; wrMaskFlags = 0; wrMaskCtrl = 0;
    excValid = 0; restoreReq = 0; flagsWe = 0;
  endtask

  task automatic doReset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic setMsr(input logic [3:0] f, input logic [7:0] i8,
                        input logic [3:0] r, input logic [31:0] rv);
    {wrSaved, wrUseImm, wrMaskFlags, wrMaskCtrl} = f;
    wrImm8 = i8; wrRot = r; wrRegVal = rv; wrValid = 1;
  endtask

  task automatic readBoth(output logic [31:0] c, output logic [31:0] s);
    rdSaved = 1; #1 s = rdData;
    rdSaved = 0; #1 c = rdData;
  endtask

  initial begin
    #200000ns;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] c, s;
    doReset();
    // R1 reset state
    chk("R1 cpsr", cpsr, 32'h0000_00D3);
    chk("R1 mode", 32'(curMode), 32'h13);
    chk("R1 priv", 32'(privileged), 32'h1);
    readBoth(c, s);
    chk("R1 saved", s, 32'h0);

    // Vector table: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      doReset();
      setMsr(4'b0011, 8'h00, 4'h0, {24'h0, VEC[v][119:112]});
      tick();
      setMsr(VEC[v][111:108], VEC[v][107:100], VEC[v][99:96], VEC[v][95:64]);
      tick();
      readBoth(c, s);
      chk($sformatf("R4 R7 R8 vec%0d cpsr", v), c, VEC[v][63:32]);
      chk($sformatf("R3 R5 R6 vec%0d read", v), s, VEC[v][31:0]);
    end

    // R2 decode
    doReset();
    setMsr(4'b0001, 8'h00, 4'h0, 32'h11); tick();
    chk("R2 fiq mode", 32'(curMode), 32'h11);
    chk("R2 fiq priv", 32'(privileged), 32'h1);
    setMsr(4'b0001, 8'h00, 4'h0, 32'h1F); tick();
    chk("R2 unknown mode", 32'(curMode), 32'h10);
    chk("R2 unknown priv", 32'(privileged), 32'h0);
    doReset();
    setMsr(4'b0001, 8'h00, 4'h0, 32'h00); tick();
    chk("R2 safe mode", 32'(curMode), 32'h00);
    chk("R2 safe priv", 32'(privileged), 32'h0);

    // R9 exception entry and R10 restore
    doReset();
    setMsr(4'b0010, 8'h00, 4'h0, 32'hA000_0000); tick();
    setMsr(4'b0001, 8'h00, 4'h0, 32'h10); tick();
    chk("R9 setup", cpsr, 32'hA000_0010);
    excValid = 1; excMode = 5'b10010; excFiqDis = 0; tick();
    readBoth(c, s);
    chk("R9 cpsr", c, 32'hA000_0092);
    chk("R9 saved", s, 32'hA000_0010);
    restoreReq = 1; tick();
    chk("R10 restore", cpsr, 32'hA000_0010);
    chk("R10 priv", 32'(privileged), 32'h0);
    restoreReq = 1; tick();
    chk("R10 unpriv restore", cpsr, 32'hA000_0010);

    // R12 exception with ALU flags in same cycle
    excValid = 1; excMode = 5'b10001; excFiqDis = 1; flagsWe = 1; flagsIn = 4'h5; tick();
    readBoth(c, s);
    chk("R12 exc vs flags cpsr", c, 32'hA000_00D1);
    chk("R12 exc vs flags saved", s, 32'hA000_0010);

    // R11 flag port alone
    flagsWe = 1; flagsIn = 4'h3; tick();
    chk("R11 flags", cpsr, 32'h3000_00D1);

    // R12 restore wins over status write
    restoreReq = 1; setMsr(4'b0010, 8'h00, 4'h0, 32'hF000_0000); tick();
    chk("R12 restore vs write", cpsr, 32'hA000_0010);

    // R12 saved write plus flag port
    excValid = 1; excMode = 5'b10011; excFiqDis = 0; tick();
    chk("R9 svc entry", cpsr, 32'hA000_0093);
    setMsr(4'b1010, 8'h00, 4'h0, 32'h5000_0000); flagsWe = 1; flagsIn = 4'hC; tick();
    readBoth(c, s);
    chk("R12 saved+flags cpsr", c, 32'hC000_0093);
    chk("R12 saved+flags saved", s, 32'h5000_0010);

    // R11 flag port dropped under a status write to cpsr
    setMsr(4'b0010, 8'h00, 4'h0, 32'h1000_0000); flagsWe = 1; flagsIn = 4'hF; tick();
    chk("R11 dropped", cpsr, 32'h1000_0093);

    finishRun();
  end
endmodule